// File: doc/BRIEF.md
# Ring Buffer Pointer Watermark Unit

This block keeps the pointer state of one audio ring buffer that lives in system memory. Software programs a base address, a last-valid-byte address, a read pointer, a write pointer and a watermark value through a small register bus. The top bit of each pointer is not part of the address. It is a lap flag that flips each time the pointer wraps. Equal addresses with equal flags mean an empty buffer. Equal addresses with different flags mean a full one.

A hardware strobe advances the pointer owned by the hardware side. That is the read pointer when the unit drains toward an output (playback) and the write pointer when it fills from an input (capture). From the two pointers the unit derives the filled byte count and the byte position of the hardware pointer. It compares the free space (playback) or the filled space (capture) against the mark. The watermark event fires once the count strictly exceeds the mark, then stays latched and disarmed until software writes a re-arm command. A request that cannot proceed, such as draining an empty buffer or filling a full one, is refused and flagged.

Top module: `ringbuf_mark_unit`

## Requirements
- R1: After reset all five registers read zero, `mark_evt` and `xrun` are 0, and the watermark comparator is disarmed.
- R2: A bus write with `bus_addr` 0 (base), 1 (end, last valid byte), 2 (read pointer), 3 (write pointer) or 4 (mark) updates that register at the clock edge and reads back through `bus_rdata`. Address 5 is the command register, whose write-only bit 0 re-arms the comparator.
- R3: `fill_bytes` is write minus read (low PW-1 bits) when the two top bits are equal, and that difference plus the buffer size (end − base + 1) when they differ. Equal low bits with different top bits therefore give the full size, and with equal top bits give 0.
- R4: Each `hw_req` that is accepted advances the hardware pointer by STEP bytes. If the new address would pass the end address, the pointer is loaded with the base address and its top bit is inverted.
- R5: With `mode_play`=1 the compared count is size − fill. With `mode_play`=0 it is fill. The event sets only when the count is strictly greater than the mark.
- R6: Once set, `mark_evt` stays 1 and the comparator stays disarmed until a write of 1 to command bit 0. That write clears `mark_evt` at the same edge, and the event can set again on the following edge.
- R7: `pos_bytes` is the hardware pointer's low PW-1 bits minus the base's low PW-1 bits.
- R8: In playback mode, `hw_req` while the buffer is empty leaves the read pointer unchanged and pulses `xrun` for one cycle after the edge.
- R9: In capture mode, `hw_req` while the buffer is full leaves the write pointer unchanged and pulses `xrun` for one cycle after the edge.
- R10: A software pointer write changes the compared count from the next cycle on, and the event reflects it one edge later. A software write wins over a same-cycle hardware advance of the same pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_play | input | 1 | 1 = hardware drains (playback), 0 = hardware fills (capture) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | PW | Write data |
| bus_rdata | output | PW | Read data of the addressed register |
| hw_req | input | 1 | Advance the hardware-side pointer by STEP bytes |
| fill_bytes | output | PW | Bytes currently held in the buffer |
| pos_bytes | output | PW-1 | Offset of the hardware pointer from base |
| mark_evt | output | 1 | Latched watermark event |
| xrun | output | 1 | One-cycle pulse for a refused request |

## Verification
Every cycle, assertions check the following. A refused request never moves the pointer. The xrun pulse only follows a request. The latched event holds until re-armed. A re-arm write clears the event. The event never rises while the comparator is disarmed.

Other behaviours can only be shown by the bench scenarios. These are the fill arithmetic across a lap, the wrap to base with the flag flip, the strict boundary where count equals mark, and the swap between free and filled counts by mode. The bench sweeps every mark across every fill step in both modes to cover them.

// File: rtl/ringbuf_mark_unit.sv
module ringbuf_mark_unit #(
  parameter int PW   = 32,
  parameter int STEP = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_play,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [PW-1:0] bus_wdata,
  output logic [PW-1:0] bus_rdata,
  input  logic          hw_req,
  output logic [PW-1:0] fill_bytes,
  output logic [PW-2:0] pos_bytes,
  output logic          mark_evt,
  output logic          xrun
);
  localparam int LW = PW - 1;

  logic [PW-1:0] base_q, end_q, rd_q, wr_q, mark_q;
  logic          armed_q;

  logic [PW-1:0] size_w, diff_w, cnt_w, hw_ptr, hw_nxt;
  logic [LW:0]   sum_w;
  logic          same_lap, empty_w, full_w, blocked, adv;
  logic          wr_base, wr_end, wr_rd, wr_wr, wr_mark, rearm;

  assign wr_base = bus_wr && bus_addr == 3'd0;
  assign wr_end  = bus_wr && bus_addr == 3'd1;
  assign wr_rd   = bus_wr && bus_addr == 3'd2;
  assign wr_wr   = bus_wr && bus_addr == 3'd3;
  assign wr_mark = bus_wr && bus_addr == 3'd4;
  assign rearm   = bus_wr && bus_addr == 3'd5 && bus_wdata[0];

  assign same_lap   = rd_q[PW-1] == wr_q[PW-1];
  assign size_w     = {1'b0, end_q[LW-1:0]} - {1'b0, base_q[LW-1:0]} + PW'(1);
  assign diff_w     = {1'b0, wr_q[LW-1:0]} - {1'b0, rd_q[LW-1:0]};
  assign fill_bytes = same_lap ? diff_w : diff_w + size_w;
  assign empty_w    = same_lap && rd_q[LW-1:0] == wr_q[LW-1:0];
  assign full_w     = !same_lap && rd_q[LW-1:0] == wr_q[LW-1:0];
  assign cnt_w      = mode_play ? size_w - fill_bytes : fill_bytes;

  assign hw_ptr    = mode_play ? rd_q : wr_q;
  assign pos_bytes = hw_ptr[LW-1:0] - base_q[LW-1:0];
  assign blocked   = mode_play ? empty_w : full_w;
  assign adv       = hw_req && !blocked;

  always_comb begin
    sum_w = {1'b0, hw_ptr[LW-1:0]} + (LW+1)'(STEP);
    if (sum_w > {1'b0, end_q[LW-1:0]})
      hw_nxt = {~hw_ptr[PW-1], base_q[LW-1:0]};
    else
      hw_nxt = {hw_ptr[PW-1], sum_w[LW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0; end_q <= '0; rd_q <= '0; wr_q <= '0; mark_q <= '0;
    end else begin
      if (wr_base) base_q <= bus_wdata;
      if (wr_end)  end_q  <= bus_wdata;
      if (wr_mark) mark_q <= bus_wdata;
      if (wr_rd)                       rd_q <= bus_wdata;
      else if (adv && mode_play)       rd_q <= hw_nxt;
      if (wr_wr)                       wr_q <= bus_wdata;
      else if (adv && !mode_play)      wr_q <= hw_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0; mark_evt <= 1'b0; xrun <= 1'b0;
    end else begin
      xrun <= hw_req && blocked;
      if (rearm) begin
        armed_q  <= 1'b1;
        mark_evt <= 1'b0;
      end else if (armed_q && cnt_w > mark_q) begin
        armed_q  <= 1'b0;
        mark_evt <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = base_q;
      3'd1:    bus_rdata = end_q;
      3'd2:    bus_rdata = rd_q;
      3'd3:    bus_rdata = wr_q;
      3'd4:    bus_rdata = mark_q;
      default: bus_rdata = '0;
    endcase
  end

  p_no_drain_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_play && hw_req && empty_w && !wr_rd) |=> $stable(rd_q));
  p_no_fill_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_play && hw_req && full_w && !wr_wr) |=> $stable(wr_q));
  p_xrun_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xrun |-> $past(hw_req));
  p_evt_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_evt && !rearm) |=> mark_evt);
  p_rearm_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !mark_evt);
  p_no_rise_disarmed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !rearm) |=> !$rose(mark_evt));
endmodule

// File: tb/tb_ringbuf_mark_unit.sv
module tb_ringbuf_mark_unit;
  localparam int PW = 32;
  localparam int STEP = 256;
  localparam logic [31:0] B = 32'h0000_1000;
  localparam logic [31:0] LAP = 32'h8000_0000;
  localparam int SZ = 2048;

  logic clk = 0, rst_n = 0, mode_play = 0, bus_wr = 0, hw_req = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, fill_bytes;
  logic [30:0] pos_bytes;
  logic mark_evt, xrun;
  int checks = 0, fails = 0;

  ringbuf_mark_unit #(.PW(PW), .STEP(STEP)) dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  task automatic req();
    hw_req = 1;
    @(negedge clk);
    hw_req = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    for (int a = 0; a < 5; a++) begin
      bus_addr = 3'(a); #1;
      chk("R1 reg", bus_rdata, 0);
    end
    bus_addr = 0;
    chk("R1 evt", {31'b0, mark_evt}, 0);
    chk("R1 xrun", {31'b0, xrun}, 0);
    // R1 disarmed: capture mode, fill made large, no event
    wreg(3'd1, 32'h0000_0FFF);
    wreg(3'd3, 32'h0000_0800);
    @(negedge clk);
    chk("R1 disarmed", {31'b0, mark_evt}, 0);
    // R2 readback
    wreg(3'd4, 32'h0000_0300);
    bus_addr = 3'd4; #1; chk("R2 mark", bus_rdata, 32'h300);
    bus_addr = 3'd1; #1; chk("R2 end", bus_rdata, 32'hFFF);
    bus_addr = 3'd3; #1; chk("R2 wr", bus_rdata, 32'h800);
    bus_addr = 0;

    for (int play = 0; play < 2; play++) begin
      for (int m = 0; m < 8; m++) begin
        mode_play = play[0];
        wreg(3'd0, B);
        wreg(3'd1, B + SZ - 1);
        wreg(3'd4, 32'(m * STEP));
        wreg(3'd2, B);
        wreg(3'd3, play ? (B | LAP) : B);
        wreg(3'd5, 32'h1);
        // R3 start: playback full, capture empty
        chk("R3 start fill", fill_bytes, play ? SZ : 0);
        for (int k = 1; k <= 8; k++) begin
          req();
          chk("R3/R4 fill", fill_bytes, play ? 32'(SZ - k * STEP) : 32'(k * STEP));
          chk("R4/R7 pos", {1'b0, pos_bytes}, 32'((k * STEP) % SZ));
          chk(play ? "R8 no xrun" : "R9 no xrun", {31'b0, xrun}, 0);
          @(negedge clk);
          chk("R5 evt strict", {31'b0, mark_evt}, {31'b0, k > m});
        end
        // R4 wrap toggles lap bit of hardware pointer
        bus_addr = play ? 3'd2 : 3'd3; #1;
        chk("R4 wrap ptr", bus_rdata, B | LAP);
        bus_addr = 0;
        // R8/R9 refused request
        req();
        chk(play ? "R8 xrun" : "R9 xrun", {31'b0, xrun}, 1);
        bus_addr = play ? 3'd2 : 3'd3; #1;
        chk(play ? "R8 rd held" : "R9 wr held", bus_rdata, B | LAP);
        bus_addr = 0;
        @(negedge clk);
        chk("R8/R9 pulse end", {31'b0, xrun}, 0);
        // R6 re-arm clears then refires
        wreg(3'd5, 32'h1);
        chk("R6 rearm clear", {31'b0, mark_evt}, 0);
        @(negedge clk);
        chk("R6 refire", {31'b0, mark_evt}, 1);
      end
    end

    // R6 latch: count drops below mark, event stays
    mode_play = 0;
    wreg(3'd3, B);
    wreg(3'd2, B);
    @(negedge clk);
    chk("R6 latched", {31'b0, mark_evt}, 1);
    // R10 software pointer write drives compare
    wreg(3'd4, 32'h100);
    wreg(3'd5, 32'h1);
    @(negedge clk);
    chk("R10 below mark", {31'b0, mark_evt}, 0);
    wreg(3'd3, B + 32'h200);
    chk("R10 fill now", fill_bytes, 32'h200);
    chk("R10 evt not yet", {31'b0, mark_evt}, 0);
    @(negedge clk);
    chk("R10 evt", {31'b0, mark_evt}, 1);
    // R10 software write wins over hardware advance
    bus_wr = 1; bus_addr = 3'd3; bus_wdata = B + 32'h500; hw_req = 1;
    @(negedge clk);
    bus_wr = 0; hw_req = 0; bus_addr = 3'd3; #1;
    chk("R10 sw wins", bus_rdata, B + 32'h500);
    bus_addr = 0;
    // R3 lap arithmetic: wr behind rd on other lap
    wreg(3'd2, B + 32'h600);
    wreg(3'd3, (B + 32'h200) | LAP);
    chk("R3 lap fill", fill_bytes, 32'h400);
    finish_run();
  end
endmodule